// File: doc/BRIEF.md
# Protection Region Configuration Register Bank

This block holds the state of a physical-memory-protection unit: one 8-bit configuration byte and one address register for each of 16 entries, plus a three-bit machine security policy register. Software reaches it through a simple register port. A port select chooses the packed configuration words, the address registers or the security register. The index names a word or an entry. Each write lands at a clock edge, and reads return at once.

The bank enforces the write rules of the protection scheme. A locked entry cannot be rewritten unless the lock-bypass bit is set. A locked top-of-range neighbour also guards the address register below it. The lockdown and whitelist policy bits cannot be cleared once they are set. While lockdown is on, the bank refuses config bytes that would create an executable machine-only region or a locked shared region. Downstream range-decode and access-check logic reads the flattened config and address outputs and the enabled-entry count. It uses the flush pulse to discard any cached permission results.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset every config byte, address register and security bit reads zero, the enabled count is 0 and flush is low.
- R2: With select 0, a write to word w splits the data into four bytes. Byte i (bits 8i+7:8i) goes to entry 4w+i. Each config byte has read at bit 0, write at bit 1, execute at bit 2, match mode at bits 4:3 (0 off, 1 top-of-range, 2 naturally-aligned 4-byte, 3 power-of-two) and lock at bit 7.
- R3: An entry is read-only when its lock bit is 1 and the bypass bit is 0. Config and address writes to a read-only entry are ignored. When the bypass bit is 1, the same writes are accepted.
- R4: A write to address register k (select 1) is ignored when entry k+1 is read-only and its match mode is top-of-range. A locked neighbour in any other mode does not block the write.
- R5: While lockdown is 1 and bypass is 0, a config byte is rejected if its code {lock, read, write, exec} (lock as MSB) is 9, 10, 11 or 13. Other codes are accepted. When bypass is 1, no code is rejected.
- R6: The security register (select 2) has lockdown at bit 0, whitelist at bit 1 and bypass at bit 2. Lockdown and whitelist stay 1 after they are set, until reset.
- R7: The bypass bit cannot change from 0 to 1 while any entry has its lock bit set. Clearing it is always allowed.
- R8: The enabled count equals the number of entries whose match mode is not off, and it follows every config change.
- R9: Flush is high for the cycle after any write that changes a stored value. A write equal to the current contents, or a rejected write, gives no flush.
- R10: Config words past the last entry, address indices of 16 or more, and select 3 all read zero. Writes to them are ignored.
- R11: The read data reflects the register selected by select and index in the same cycle, packed the same way it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe |
| csr_sel | input | 2 | 0 config word, 1 address, 2 security, 3 none |
| csr_idx | input | 6 | Word or entry index |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for current select and index |
| entry_cfg_o | output | 128 | Config bytes, entry e at bits 8e+7:8e |
| entry_addr_o | output | 512 | Address registers, entry e at bits 32e+31:32e |
| active_cnt_o | output | 5 | Number of entries with match mode not off |
| sec_mml_o | output | 1 | Lockdown policy bit |
| sec_mmwp_o | output | 1 | Whitelist policy bit |
| sec_rlb_o | output | 1 | Lock bypass bit |
| flush_o | output | 1 | One-cycle pulse after an accepted change |

## Verification
The bench targets the lock rules in detail. If the top-of-range guard were left out, an address register below a locked neighbour would take new values. If a non-top-of-range neighbour also blocked writes, a legal address update would be lost. Each of the four rejected lockdown codes is written next to an accepted code in the same word. This catches a decoder that orders the lock, read, write and exec bits wrongly. Sticky policy bits, a bypass attempt while a lock exists, same-value rewrites that must not flush, and indices past the bank are each checked at the read port and on the flush output.

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank #(
  parameter int N_ENT = 16,
  parameter int AW    = 32,
  parameter int IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csr_we,
  input  logic [1:0]             csr_sel,
  input  logic [IDX_W-1:0]       csr_idx,
  input  logic [31:0]            csr_wdata,
  output logic [31:0]            csr_rdata,
  output logic [N_ENT*8-1:0]     entry_cfg_o,
  output logic [N_ENT*AW-1:0]    entry_addr_o,
  output logic [$clog2(N_ENT+1)-1:0] active_cnt_o,
  output logic                   sec_mml_o,
  output logic                   sec_mmwp_o,
  output logic                   sec_rlb_o,
  output logic                   flush_o
);
  localparam int CW = $clog2(N_ENT+1);
  localparam logic [1:0] SEL_CFG = 2'd0, SEL_ADR = 2'd1, SEL_SEC = 2'd2;
  localparam logic [1:0] MODE_TOR = 2'd1;

  logic [7:0]    cfg_q  [N_ENT];
  logic [7:0]    cfg_d  [N_ENT];
  logic [AW-1:0] addr_q [N_ENT];
  logic [AW-1:0] addr_d [N_ENT];
  logic mml_q, mmwp_q, rlb_q, mml_d, mmwp_d, rlb_d, chg;
  logic [N_ENT-1:0] ro, lk, tor_guard;

  function automatic logic bad_code(input logic [7:0] v, input logic mml, input logic rlb);
    logic [3:0] c;
    c = {v[7], v[0], v[1], v[2]};
    return mml && !rlb && (c == 4'd9 || c == 4'd10 || c == 4'd11 || c == 4'd13);
  endfunction

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign lk[e] = cfg_q[e][7];
    assign ro[e] = cfg_q[e][7] & ~rlb_q;
    if (e + 1 < N_ENT) begin : g_nb
      assign tor_guard[e] = ro[e+1] && (cfg_q[e+1][4:3] == MODE_TOR);
    end else begin : g_last
      assign tor_guard[e] = 1'b0;
    end
    assign entry_cfg_o[e*8 +: 8]    = cfg_q[e];
    assign entry_addr_o[e*AW +: AW] = addr_q[e];
  end

  always_comb begin
    cfg_d  = cfg_q;
    addr_d = addr_q;
    mml_d  = mml_q;
    mmwp_d = mmwp_q;
    rlb_d  = rlb_q;
    chg    = 1'b0;
    if (csr_we) begin
      case (csr_sel)
        SEL_CFG: begin
          for (int e = 0; e < N_ENT; e++) begin
            if (int'(csr_idx) == e / 4) begin
              if (csr_wdata[(e%4)*8 +: 8] != cfg_q[e] && !ro[e] &&
                  !bad_code(csr_wdata[(e%4)*8 +: 8], mml_q, rlb_q)) begin
                cfg_d[e] = csr_wdata[(e%4)*8 +: 8];
                chg = 1'b1;
              end
            end
          end
        end
        SEL_ADR: begin
          for (int e = 0; e < N_ENT; e++) begin
            if (int'(csr_idx) == e && csr_wdata[AW-1:0] != addr_q[e] &&
                !ro[e] && !tor_guard[e]) begin
              addr_d[e] = csr_wdata[AW-1:0];
              chg = 1'b1;
            end
          end
        end
        SEL_SEC: begin
          mml_d  = mml_q  | csr_wdata[0];
          mmwp_d = mmwp_q | csr_wdata[1];
          rlb_d  = csr_wdata[2] & (rlb_q | ~(|lk));
          chg    = (mml_d != mml_q) || (mmwp_d != mmwp_q) || (rlb_d != rlb_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) begin
        cfg_q[e]  <= '0;
        addr_q[e] <= '0;
      end
      mml_q   <= 1'b0;
      mmwp_q  <= 1'b0;
      rlb_q   <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      addr_q  <= addr_d;
      mml_q   <= mml_d;
      mmwp_q  <= mmwp_d;
      rlb_q   <= rlb_d;
      flush_o <= chg;
    end
  end

  always_comb begin
    active_cnt_o = '0;
    for (int e = 0; e < N_ENT; e++)
      active_cnt_o = active_cnt_o + CW'(cfg_q[e][4:3] != 2'd0);
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      SEL_CFG:
        for (int e = 0; e < N_ENT; e++)
          if (int'(csr_idx) == e / 4) csr_rdata[(e%4)*8 +: 8] = cfg_q[e];
      SEL_ADR:
        for (int e = 0; e < N_ENT; e++)
          if (int'(csr_idx) == e) csr_rdata[AW-1:0] = addr_q[e];
      SEL_SEC: csr_rdata[2:0] = {rlb_q, mmwp_q, mml_q};
      default: ;
    endcase
  end

  assign sec_mml_o  = mml_q;
  assign sec_mmwp_o = mmwp_q;
  assign sec_rlb_o  = rlb_q;
endmodule

module pmp_csr_bank_chk #(
  parameter int N_ENT = 16,
  parameter int AW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                csr_we,
  input logic [N_ENT*8-1:0]  entry_cfg_o,
  input logic [N_ENT*AW-1:0] entry_addr_o,
  input logic                sec_mml_o,
  input logic                sec_mmwp_o,
  input logic                sec_rlb_o,
  input logic                flush_o
);
  logic any_lock;
  always_comb begin
    any_lock = 1'b0;
    for (int e = 0; e < N_ENT; e++) any_lock = any_lock | entry_cfg_o[e*8+7];
  end

  // R9
  flush_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(csr_we));

  // R6
  mml_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mml_o |=> sec_mml_o);

  // R6
  mmwp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mmwp_o |=> sec_mmwp_o);

  // R7
  rlb_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_rlb_o && any_lock) |=> !sec_rlb_o);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ro
    // R3
    ro_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_cfg_o[e*8+7] && !sec_rlb_o) |=> $stable(entry_cfg_o[e*8 +: 8]));
    // R3
    ro_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_cfg_o[e*8+7] && !sec_rlb_o) |=> $stable(entry_addr_o[e*AW +: AW]));
  end
endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(.N_ENT(N_ENT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .entry_cfg_o(entry_cfg_o),
  .entry_addr_o(entry_addr_o), .sec_mml_o(sec_mml_o), .sec_mmwp_o(sec_mmwp_o),
  .sec_rlb_o(sec_rlb_o), .flush_o(flush_o));

// File: tb/pmp_csr_bank_tb.sv
module pmp_csr_bank_tb;
  localparam int CLK_P = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0, csr_we = 1'b0;
  logic [1:0] csr_sel = '0;
  logic [5:0] csr_idx = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic [N*8-1:0] entry_cfg_o;
  logic [N*32-1:0] entry_addr_o;
  logic [4:0] active_cnt_o;
  logic sec_mml_o, sec_mmwp_o, sec_rlb_o, flush_o;
  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pmp_csr_bank u_dut (.clk, .rst_n, .csr_we, .csr_sel, .csr_idx, .csr_wdata,
    .csr_rdata, .entry_cfg_o, .entry_addr_o, .active_cnt_o, .sec_mml_o,
    .sec_mmwp_o, .sec_rlb_o, .flush_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; csr_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // write, then sample flush in the cycle after the write edge
  task automatic wr(input logic [1:0] s, input int i, input logic [31:0] d, input logic exp_flush, input string req);
    csr_sel = s; csr_idx = 6'(i); csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    chk({req, " flush"}, 32'(flush_o), 32'(exp_flush));
  endtask

  task automatic rd(input logic [1:0] s, input int i, input logic [31:0] exp, input string req);
    csr_sel = s; csr_idx = 6'(i);
    #1;
    chk({req, " read"}, csr_rdata, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cfg", 32'(|entry_cfg_o), 0);
    chk("R1 addr", 32'(|entry_addr_o), 0);
    chk("R1 count", 32'(active_cnt_o), 0);
    chk("R1 flush", 32'(flush_o), 0);
    rd(2'd2, 0, 0, "R1 sec");
  endtask

  task automatic t_pack();
    do_reset();
    wr(2'd0, 1, 32'h18100803, 1'b1, "R2 write");
    rd(2'd0, 1, 32'h18100803, "R11 word1");
    chk("R2 entry5 byte", 32'(entry_cfg_o[5*8 +: 8]), 32'h08);
    chk("R2 entry7 byte", 32'(entry_cfg_o[7*8 +: 8]), 32'h18);
    chk("R8 count", 32'(active_cnt_o), 3);
    @(negedge clk);
    chk("R9 pulse ends", 32'(flush_o), 0);
    wr(2'd0, 1, 32'h18100803, 1'b0, "R9 same value");
    wr(2'd0, 1, 32'h00100803, 1'b1, "R8 drop one");
    chk("R8 count after", 32'(active_cnt_o), 2);
    wr(2'd1, 2, 32'h00001234, 1'b1, "R11 addr");
    rd(2'd1, 2, 32'h00001234, "R11 addr2");
    chk("R11 flat addr", entry_addr_o[2*32 +: 32], 32'h1234);
  endtask

  task automatic t_lock();
    do_reset();
    wr(2'd1, 0, 32'h11, 1'b1, "R3 pre addr");
    wr(2'd0, 0, 32'h00000089, 1'b1, "R3 lock");
    wr(2'd0, 0, 32'h00000000, 1'b0, "R3 cfg ignored");
    rd(2'd0, 0, 32'h89, "R3 cfg kept");
    wr(2'd1, 0, 32'h22, 1'b0, "R3 addr ignored");
    rd(2'd1, 0, 32'h11, "R3 addr kept");
    // bypass set before lock: writes to locked entry accepted
    do_reset();
    wr(2'd2, 0, 32'h4, 1'b1, "R3 set bypass");
    wr(2'd0, 0, 32'h00000089, 1'b1, "R3 lock w/ bypass");
    wr(2'd0, 0, 32'h00000000, 1'b1, "R3 bypass rewrite");
    rd(2'd0, 0, 32'h0, "R3 bypass cfg");
    chk("R8 count zero", 32'(active_cnt_o), 0);
  endtask

  task automatic t_tor();
    do_reset();
    wr(2'd0, 0, 32'h00008800, 1'b1, "R4 lock tor e1");
    wr(2'd1, 0, 32'h55, 1'b0, "R4 addr0 blocked");
    rd(2'd1, 0, 32'h0, "R4 addr0");
    wr(2'd1, 2, 32'h77, 1'b1, "R4 addr2 free");
    rd(2'd1, 2, 32'h77, "R4 addr2");
    do_reset();
    wr(2'd0, 0, 32'h00009000, 1'b1, "R4 lock na4 e1");
    wr(2'd1, 0, 32'h55, 1'b1, "R4 addr0 allowed");
    rd(2'd1, 0, 32'h55, "R4 addr0 na4");
  endtask

  task automatic t_sec();
    do_reset();
    wr(2'd2, 0, 32'h3, 1'b1, "R6 set");
    rd(2'd2, 0, 32'h3, "R6 set");
    wr(2'd2, 0, 32'h0, 1'b0, "R6 clear attempt");
    rd(2'd2, 0, 32'h3, "R6 sticky");
    do_reset();
    wr(2'd0, 0, 32'h00000080, 1'b1, "R7 lock");
    wr(2'd2, 0, 32'h4, 1'b0, "R7 bypass blocked");
    rd(2'd2, 0, 32'h0, "R7 bypass");
    do_reset();
    wr(2'd2, 0, 32'h4, 1'b1, "R7 bypass set");
    wr(2'd0, 0, 32'h00000080, 1'b1, "R7 lock");
    wr(2'd2, 0, 32'h0, 1'b1, "R7 bypass clear");
    rd(2'd2, 0, 32'h0, "R7 cleared");
  endtask

  task automatic t_mml();
    do_reset();
    wr(2'd2, 0, 32'h1, 1'b1, "R5 lockdown");
    wr(2'd0, 0, 32'h00000084, 1'b0, "R5 code9");
    wr(2'd0, 0, 32'h00008200, 1'b0, "R5 code10");
    rd(2'd0, 0, 32'h0, "R5 none");
    wr(2'd0, 0, 32'h85860087, 1'b1, "R5 mix");
    rd(2'd0, 0, 32'h00000087, "R5 only code15");
    do_reset();
    wr(2'd2, 0, 32'h5, 1'b1, "R5 lockdown+bypass");
    wr(2'd0, 0, 32'h00000084, 1'b1, "R5 bypass accept");
    rd(2'd0, 0, 32'h84, "R5 bypass cfg");
  endtask

  task automatic t_oob();
    do_reset();
    wr(2'd0, 4, 32'h0F0F0F0F, 1'b0, "R10 cfg word4");
    rd(2'd0, 4, 32'h0, "R10 word4");
    chk("R10 count", 32'(active_cnt_o), 0);
    wr(2'd1, 20, 32'h99, 1'b0, "R10 addr20");
    rd(2'd1, 20, 32'h0, "R10 addr20");
    chk("R10 no addr", 32'(|entry_addr_o), 0);
    wr(2'd3, 0, 32'hFFFFFFFF, 1'b0, "R10 sel3");
    rd(2'd3, 0, 32'h0, "R10 sel3");
    rd(2'd2, 0, 32'h0, "R10 sec untouched");
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pack();
    t_lock();
    t_tor();
    t_sec();
    t_mml();
    t_oob();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule